// File: doc/BRIEF.md
# SPI Frame Capture Buffer

This block holds one image frame, stored in a byte-wide buffer, and gives an SPI host access to it through a small register set. The host sends a start command. The block then waits for the next rising edge of the frame-sync input. From that point it stores every byte presented with the pixel-valid strobe, until the next frame-sync rising edge ends the frame and raises a completion flag. The host polls the status register for that flag and reads the stored byte count from three length registers. It then empties the buffer, either with a streaming read command or one byte per transaction, and clears the flag.

Each SPI transaction begins with an address byte. Bit 7 of that byte selects a write (1) or a read (0). The SPI link uses mode 0, MSB first. SCK, chip select and MOSI are resynchronised into the much faster system clock. A general-purpose register pair (direction and output) drives sensor reset, power-down and power enable. A third register reports the levels on the general-purpose input pins.

Top module: `spi_frame_capture`

## Requirements
- R1: After reset, `gpio_out`, `gpio_dir` and `spi_miso` are 0, the done flag is clear and the stored length reads 0.
- R2: In a transaction whose first byte has bit 7 clear, the register named by bits 6:0 is returned MSB first during the second byte. Address 0x40 returns the `VERSION` parameter. Unmapped addresses return 0x00.
- R3: In a transaction whose first byte has bit 7 set, the second byte is stored. Address 0x05 drives `gpio_dir` and address 0x06 drives `gpio_out` (bit 0 sensor reset, bit 1 power-down, bit 2 power enable). Both read back at the same addresses.
- R4: A read of address 0x45 returns `gpio_in`.
- R5: Writing 0x04 with bit 1 set arms a capture. Bytes are stored only between the first and second frame-sync rising edges after arming, one per cycle with `pix_valid` high. The second edge sets the done flag.
- R6: The stored byte count reads as bits 7:0 at 0x42, bits 15:8 at 0x43 and bits 22:16 at 0x44. Bit 7 of 0x44 is always 0.
- R7: Each byte after address 0x3C, while chip select stays low, returns the next stored byte in capture order. The first such burst after a start command returns one 0x00 dummy byte first. Later bursts resume where the last one stopped, with no dummy.
- R8: A read at 0x3D returns the next stored byte and advances by one.
- R9: Once every stored byte has been read, further data reads return 0x00 and do not advance.
- R10: Bytes arriving with the buffer holding `DEPTH` bytes are dropped, and the count stays at `DEPTH`.
- R11: Writing 0x04 acts on these bits: bit 0 clears the done flag, bit 5 restarts reading from the first stored byte, and bit 4 empties the buffer so the count reads 0.
- R12: The status register 0x41 returns the frame-sync level on bit 0, the shutter input on bit 1 and the done flag on bit 3. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from the host |
| spi_miso | output | 1 | SPI data to the host |
| frame_sync | input | 1 | Frame-sync level from the sensor, system clock domain |
| pix_valid | input | 1 | Pixel byte strobe |
| pix_data | input | 8 | Pixel byte |
| shutter_in | input | 1 | Shutter level, reported in status |
| gpio_in | input | 8 | General-purpose input levels |
| gpio_dir | output | 8 | General-purpose direction register |
| gpio_out | output | 8 | General-purpose output register |

## Verification
The bench builds the block with `DEPTH` = 16 and leaves `VERSION` and the synchroniser depth at their defaults. The small depth means a 20-byte frame fills the buffer. This exercises dropped writes, the count saturating at the depth, and a burst that runs past the last stored byte into 0x00 fill. With the default SCK timing the synchroniser delay is much shorter than half an SCK period, so every reply byte is loaded before the host samples it.

// File: rtl/fcap_pkg.sv
package fcap_pkg;
  localparam int unsigned LEN_W = 23;

  typedef enum logic [1:0] {
    CAP_IDLE   = 2'd0,
    CAP_ARMED  = 2'd1,
    CAP_ACTIVE = 2'd2
  } cap_state_e;

  localparam logic [6:0] A_CTRL   = 7'h04;
  localparam logic [6:0] A_IODIR  = 7'h05;
  localparam logic [6:0] A_IOOUT  = 7'h06;
  localparam logic [6:0] A_BURST  = 7'h3C;
  localparam logic [6:0] A_SINGLE = 7'h3D;
  localparam logic [6:0] A_VER    = 7'h40;
  localparam logic [6:0] A_STAT   = 7'h41;
  localparam logic [6:0] A_LEN0   = 7'h42;
  localparam logic [6:0] A_LEN1   = 7'h43;
  localparam logic [6:0] A_LEN2   = 7'h44;
  localparam logic [6:0] A_IOIN   = 7'h45;

  localparam int unsigned CB_CLR_DONE = 0;
  localparam int unsigned CB_START    = 1;
  localparam int unsigned CB_RST_WR   = 4;
  localparam int unsigned CB_RST_RD   = 5;
endpackage

// File: rtl/fcap_spi_link.sv
module fcap_spi_link #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sck,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  input  logic [7:0] tx_byte,
  output logic       spi_miso,
  output logic       sel,
  output logic       byte_start,
  output logic       byte_done,
  output logic [7:0] rx_byte
);
  logic [SYNC_STAGES:0]   sck_p;
  logic [SYNC_STAGES-1:0] cs_p;
  logic [SYNC_STAGES-1:0] mosi_p;
  logic sck_s, sck_d, mosi_s, rise, fall;
  logic [2:0] bit_cnt, bit_cnt_n;
  logic [6:0] rx_sh, rx_sh_n;
  logic [7:0] tx_sh, tx_sh_n, rx_byte_n;
  logic       done_n, start_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p  <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
    end else begin
      sck_p  <= {sck_p[SYNC_STAGES-1:0], spi_sck};
      cs_p   <= {cs_p[SYNC_STAGES-2:0], spi_cs_n};
      mosi_p <= {mosi_p[SYNC_STAGES-2:0], spi_mosi};
    end
  end

  assign sck_s  = sck_p[SYNC_STAGES-1];
  assign sck_d  = sck_p[SYNC_STAGES];
  assign mosi_s = mosi_p[SYNC_STAGES-1];
  assign sel    = ~cs_p[SYNC_STAGES-1];
  assign rise   = sck_s & ~sck_d;
  assign fall   = ~sck_s & sck_d;

  always_comb begin
    bit_cnt_n = bit_cnt;
    rx_sh_n   = rx_sh;
    tx_sh_n   = tx_sh;
    rx_byte_n = rx_byte;
    done_n    = 1'b0;
    start_n   = 1'b0;
    if (!sel) begin
      bit_cnt_n = 3'd0;
      tx_sh_n   = 8'h00;
    end else begin
      if (rise) begin
        start_n   = (bit_cnt == 3'd0);
        bit_cnt_n = bit_cnt + 3'd1;
        rx_sh_n   = {rx_sh[5:0], mosi_s};
        if (bit_cnt == 3'd7) begin
          done_n    = 1'b1;
          rx_byte_n = {rx_sh, mosi_s};
        end
      end
      if (fall) begin
        tx_sh_n = (bit_cnt == 3'd0) ? tx_byte : {tx_sh[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= 3'd0;
      rx_sh      <= 7'd0;
      tx_sh      <= 8'h00;
      rx_byte    <= 8'h00;
      byte_done  <= 1'b0;
      byte_start <= 1'b0;
    end else begin
      bit_cnt    <= bit_cnt_n;
      rx_sh      <= rx_sh_n;
      tx_sh      <= tx_sh_n;
      rx_byte    <= rx_byte_n;
      byte_done  <= done_n;
      byte_start <= start_n;
    end
  end

  assign spi_miso = tx_sh[7];

  // R2: a byte boundary only while selected, and never both events in one cycle
  p_byte_in_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> $past(sel));
  p_events_apart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({byte_start, byte_done}));
  // R1: deselection leaves the link idle with a quiet output
  p_idle_on_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (spi_miso == 1'b0));
endmodule

// File: rtl/fcap_frame_store.sv
module fcap_frame_store #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned LEN_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             wr_clr,
  input  logic             rd_pop,
  input  logic             rd_clr,
  output logic [7:0]       rd_data,
  output logic [LEN_W-1:0] length
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = AW + 1;

  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] wr_cnt, wr_cnt_n, rd_cnt, rd_cnt_n;
  logic          full, has_data, mem_we;

  assign full     = (wr_cnt == CW'(DEPTH));
  assign has_data = (rd_cnt < wr_cnt);
  assign mem_we   = wr_en && !full && !wr_clr;
  assign rd_data  = has_data ? mem[rd_cnt[AW-1:0]] : 8'h00;
  assign length   = LEN_W'(wr_cnt);

  always_comb begin
    wr_cnt_n = wr_cnt;
    rd_cnt_n = rd_cnt;
    if (wr_clr)      wr_cnt_n = '0;
    else if (mem_we) wr_cnt_n = wr_cnt + 1'b1;
    if (rd_clr)                   rd_cnt_n = '0;
    else if (rd_pop && has_data)  rd_cnt_n = rd_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_cnt <= '0;
      rd_cnt <= '0;
    end else begin
      wr_cnt <= wr_cnt_n;
      rd_cnt <= rd_cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[wr_cnt[AW-1:0]] <= wr_data;
  end

  // R10: stored count never passes the depth; a write into a full store is dropped
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt <= CW'(DEPTH));
  p_full_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !wr_clr) |=> (length == LEN_W'(DEPTH)));
  // R9: a pop past the stored data leaves the read position alone
  p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && !has_data && !rd_clr) |=> $stable(rd_cnt));
endmodule

// File: rtl/fcap_capture_fsm.sv
module fcap_capture_fsm
  import fcap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_sync,
  input  logic pix_valid,
  input  logic start,
  input  logic clr_done,
  output logic store_en,
  output logic done
);
  cap_state_e state, state_n;
  logic fs_q, fs_rise, done_n;

  assign fs_rise = frame_sync & ~fs_q;

  always_comb begin
    state_n  = state;
    done_n   = done;
    store_en = 1'b0;
    case (state)
      CAP_ARMED:  if (fs_rise) state_n = CAP_ACTIVE;
      CAP_ACTIVE: begin
        if (fs_rise) begin
          state_n = CAP_IDLE;
          done_n  = 1'b1;
        end else begin
          store_en = pix_valid;
        end
      end
      default: state_n = CAP_IDLE;
    endcase
    if (start) begin
      state_n = CAP_ARMED;
      done_n  = 1'b0;
    end else if (clr_done) begin
      done_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= CAP_IDLE;
      done  <= 1'b0;
      fs_q  <= 1'b0;
    end else begin
      state <= state_n;
      done  <= done_n;
      fs_q  <= frame_sync;
    end
  end

  // R5: completion only ends an active frame; a start re-arms with the flag clear
  p_done_from_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(state == CAP_ACTIVE));
  p_start_arms_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (state == CAP_ARMED) && !done);
endmodule

// File: rtl/spi_frame_capture.sv
module spi_frame_capture
  import fcap_pkg::*;
#(
  parameter int unsigned DEPTH       = 256,
  parameter logic [7:0]  VERSION     = 8'h62,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sck,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  input  logic       frame_sync,
  input  logic       pix_valid,
  input  logic [7:0] pix_data,
  input  logic       shutter_in,
  input  logic [7:0] gpio_in,
  output logic [7:0] gpio_dir,
  output logic [7:0] gpio_out
);
  logic rst_meta, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic             sel, byte_start, byte_done;
  logic [7:0]       rx_byte, tx_byte, tx_n;
  logic             hdr_seen, hdr_n, wr_mode, wr_mode_n, wr_done, wr_done_n;
  logic [6:0]       addr, addr_n;
  logic             pop_pend, pop_pend_n, dummy_pend, dummy_n, pop;
  logic [7:0]       gpio_dir_n, gpio_out_n, reg_rdata, status;
  logic             ctl_wr, do_start, do_clr_done, do_rst_wr, do_rst_rd;
  logic             store_en, done;
  logic [7:0]       fifo_rd_data;
  logic [LEN_W-1:0] length;

  fcap_spi_link #(.SYNC_STAGES(SYNC_STAGES)) u_link (
    .clk(clk), .rst_n(rst_sync_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .tx_byte(tx_byte), .spi_miso(spi_miso), .sel(sel),
    .byte_start(byte_start), .byte_done(byte_done), .rx_byte(rx_byte)
  );

  fcap_capture_fsm u_cap (
    .clk(clk), .rst_n(rst_sync_n), .frame_sync(frame_sync), .pix_valid(pix_valid),
    .start(do_start), .clr_done(do_clr_done), .store_en(store_en), .done(done)
  );

  fcap_frame_store #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_store (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(store_en), .wr_data(pix_data),
    .wr_clr(do_rst_wr || do_start), .rd_pop(pop), .rd_clr(do_rst_rd || do_start),
    .rd_data(fifo_rd_data), .length(length)
  );

  assign ctl_wr      = byte_done && hdr_seen && wr_mode && !wr_done;
  assign do_clr_done = ctl_wr && (addr == A_CTRL) && rx_byte[CB_CLR_DONE];
  assign do_start    = ctl_wr && (addr == A_CTRL) && rx_byte[CB_START];
  assign do_rst_wr   = ctl_wr && (addr == A_CTRL) && rx_byte[CB_RST_WR];
  assign do_rst_rd   = ctl_wr && (addr == A_CTRL) && rx_byte[CB_RST_RD];
  assign status      = {4'b0000, done, 1'b0, shutter_in, frame_sync};

  always_comb begin
    case (rx_byte[6:0])
      A_IODIR: reg_rdata = gpio_dir;
      A_IOOUT: reg_rdata = gpio_out;
      A_IOIN:  reg_rdata = gpio_in;
      A_VER:   reg_rdata = VERSION;
      A_STAT:  reg_rdata = status;
      A_LEN0:  reg_rdata = length[7:0];
      A_LEN1:  reg_rdata = length[15:8];
      A_LEN2:  reg_rdata = {1'b0, length[22:16]};
      default: reg_rdata = 8'h00;
    endcase
  end

  always_comb begin
    hdr_n      = hdr_seen;
    addr_n     = addr;
    wr_mode_n  = wr_mode;
    wr_done_n  = wr_done;
    tx_n       = tx_byte;
    pop_pend_n = pop_pend;
    dummy_n    = dummy_pend;
    gpio_dir_n = gpio_dir;
    gpio_out_n = gpio_out;
    pop        = 1'b0;
    if (!sel) begin
      hdr_n      = 1'b0;
      wr_done_n  = 1'b0;
      pop_pend_n = 1'b0;
    end else begin
      if (byte_start && pop_pend) begin
        pop        = 1'b1;
        pop_pend_n = 1'b0;
      end
      if (byte_done) begin
        tx_n = 8'h00;
        if (!hdr_seen) begin
          hdr_n     = 1'b1;
          addr_n    = rx_byte[6:0];
          wr_mode_n = rx_byte[7];
          if (!rx_byte[7]) begin
            if (rx_byte[6:0] == A_BURST && dummy_pend) begin
              dummy_n = 1'b0;
            end else if (rx_byte[6:0] == A_BURST || rx_byte[6:0] == A_SINGLE) begin
              tx_n       = fifo_rd_data;
              pop_pend_n = 1'b1;
            end else begin
              tx_n = reg_rdata;
            end
          end
        end else if (wr_mode) begin
          wr_done_n = 1'b1;
          if (!wr_done && addr == A_IODIR) gpio_dir_n = rx_byte;
          if (!wr_done && addr == A_IOOUT) gpio_out_n = rx_byte;
        end else if (addr == A_BURST) begin
          tx_n       = fifo_rd_data;
          pop_pend_n = 1'b1;
        end
      end
    end
    if (do_start) dummy_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hdr_seen   <= 1'b0;
      addr       <= 7'd0;
      wr_mode    <= 1'b0;
      wr_done    <= 1'b0;
      tx_byte    <= 8'h00;
      pop_pend   <= 1'b0;
      dummy_pend <= 1'b0;
      gpio_dir   <= 8'h00;
      gpio_out   <= 8'h00;
    end else begin
      hdr_seen   <= hdr_n;
      addr       <= addr_n;
      wr_mode    <= wr_mode_n;
      wr_done    <= wr_done_n;
      tx_byte    <= tx_n;
      pop_pend   <= pop_pend_n;
      dummy_pend <= dummy_n;
      gpio_dir   <= gpio_dir_n;
      gpio_out   <= gpio_out_n;
    end
  end

  // R3: output register moves only on a completed SPI byte
  p_gpio_hold_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !byte_done |=> $stable(gpio_out));
  // R7: the dummy byte is spent only at a header boundary
  p_dummy_spent_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(dummy_pend) |-> $past(byte_done));
  // R8: a buffer pop happens only while the host holds the link selected
  p_pop_in_sel_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pop |-> sel);
endmodule

// File: tb/tb_spi_frame_capture.sv
`timescale 1ns/1ps
module tb_spi_frame_capture;
  localparam int unsigned DEPTH = 16;
  localparam logic [7:0]  VER   = 8'h62;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, miso;
  logic fs = 1'b0, pv = 1'b0, shut = 1'b0;
  logic [7:0] pd = 8'h00, gin = 8'h00, gdir, gout;

  always #2.5 clk = ~clk;

  spi_frame_capture #(.DEPTH(DEPTH), .VERSION(VER)) dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .frame_sync(fs), .pix_valid(pv), .pix_data(pd),
    .shutter_in(shut), .gpio_in(gin), .gpio_dir(gdir), .gpio_out(gout)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];
  string      tag_q[$];
  logic [7:0] frame_m[$];
  int         rd_m = 0;
  bit         dummy_m = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pairs each received byte with its expected value
  always @(negedge clk) begin
    while (got_q.size() > 0 && exp_q.size() > 0)
      check(tag_q.pop_front(), {24'd0, got_q.pop_front()}, {24'd0, exp_q.pop_front()});
  end

  task automatic hc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      mosi = tx[b];
      hc(8);
      sck = 1'b1;
      rx[b] = miso;
      hc(8);
      sck = 1'b0;
    end
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    hc(6);
  endtask

  task automatic cs_hi();
    hc(6);
    cs_n = 1'b1;
    hc(8);
  endtask

  task automatic reg_wr(input logic [6:0] a, input logic [7:0] v);
    logic [7:0] r;
    cs_lo();
    xfer({1'b1, a}, r);
    xfer(v, r);
    cs_hi();
  endtask

  task automatic reg_rd(input logic [6:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] r;
    cs_lo();
    xfer({1'b0, a}, r);
    xfer(8'h00, r);
    cs_hi();
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    got_q.push_back(r);
  endtask

  function automatic logic [7:0] model_next();
    logic [7:0] v;
    if (rd_m < frame_m.size()) begin
      v = frame_m[rd_m];
      rd_m++;
    end else begin
      v = 8'h00;
    end
    return v;
  endfunction

  task automatic burst(input int n, input string tag);
    logic [7:0] r, e;
    cs_lo();
    xfer(8'h3C, r);
    for (int i = 0; i < n; i++) begin
      if (i == 0 && dummy_m) begin
        e = 8'h00;
        dummy_m = 1'b0;
      end else begin
        e = model_next();
      end
      xfer(8'h00, r);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      got_q.push_back(r);
    end
    cs_hi();
  endtask

  task automatic single(input string tag);
    logic [7:0] e;
    e = model_next();
    reg_rd(7'h3D, e, tag);
  endtask

  task automatic start_cmd();
    reg_wr(7'h04, 8'h02);
    frame_m.delete();
    rd_m = 0;
    dummy_m = 1'b1;
  endtask

  task automatic pix(input int n, input logic [7:0] base, input bit store);
    for (int i = 0; i < n; i++) begin
      pd = base + 8'(i);
      pv = 1'b1;
      hc(1);
      if (store && frame_m.size() < DEPTH) frame_m.push_back(base + 8'(i));
    end
    pv = 1'b0;
    hc(1);
  endtask

  task automatic fs_pulse();
    fs = 1'b1;
    hc(2);
    fs = 1'b0;
    hc(2);
  endtask

  task automatic check_len(input string tag);
    int l;
    l = frame_m.size();
    reg_rd(7'h42, 8'(l & 8'hFF), tag);
    reg_rd(7'h43, 8'((l >> 8) & 8'hFF), tag);
    reg_rd(7'h44, 8'((l >> 16) & 8'h7F), tag);
  endtask

  initial begin
    hc(5);
    rst_n = 1'b1;
    hc(6);
    // R1: reset state at the ports and through registers
    check("R1 gpio_out", {24'd0, gout}, 32'd0);
    check("R1 gpio_dir", {24'd0, gdir}, 32'd0);
    check("R1 miso", {31'd0, miso}, 32'd0);
    reg_rd(7'h41, 8'h00, "R1 status");
    check_len("R1 length");
    // R2: version and unmapped address
    reg_rd(7'h40, VER, "R2 version");
    reg_rd(7'h22, 8'h00, "R2 unmapped");
    // R3: writes and readback
    reg_wr(7'h05, 8'hA5);
    check("R3 gpio_dir", {24'd0, gdir}, 32'hA5);
    reg_wr(7'h06, 8'h05);
    check("R3 gpio_out", {24'd0, gout}, 32'h05);
    reg_rd(7'h05, 8'hA5, "R3 dir readback");
    reg_rd(7'h06, 8'h05, "R3 out readback");
    // R4: input pins
    gin = 8'h5A;
    reg_rd(7'h45, 8'h5A, "R4 gpio_in");
    // R12: status levels
    fs = 1'b1;
    hc(2);
    reg_rd(7'h41, 8'h01, "R12 fsync bit");
    shut = 1'b1;
    reg_rd(7'h41, 8'h03, "R12 shutter bit");
    fs = 1'b0;
    shut = 1'b0;
    hc(2);
    // R5: idle bytes ignored, armed bytes ignored, frame stored
    pix(3, 8'hE0, 1'b0);
    start_cmd();
    pix(2, 8'hF0, 1'b0);
    fs_pulse();
    pix(5, 8'h10, 1'b1);
    reg_rd(7'h41, 8'h00, "R5 not done mid-frame");
    fs_pulse();
    pix(2, 8'hD0, 1'b0);
    reg_rd(7'h41, 8'h08, "R5 done after frame");
    check_len("R6 length 5");
    // R7: dummy on first burst, resume on second
    burst(3, "R7 first burst");
    burst(2, "R7 second burst");
    single("R8 single read");
    single("R9 read past end");
    burst(2, "R9 burst past end");
    // R11: read restart, done clear, write reset
    reg_wr(7'h04, 8'h20);
    rd_m = 0;
    single("R11 read restart");
    reg_wr(7'h04, 8'h01);
    reg_rd(7'h41, 8'h00, "R11 done cleared");
    reg_wr(7'h04, 8'h10);
    frame_m.delete();
    check_len("R11 write reset");
    // R10: overflow of a 20-byte frame into DEPTH
    start_cmd();
    fs_pulse();
    pix(20, 8'h40, 1'b1);
    fs_pulse();
    reg_rd(7'h41, 8'h08, "R5 done second frame");
    check_len("R10 length saturates");
    burst(DEPTH + 2, "R10 overflow contents");
    hc(20);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule